// File: doc/BRIEF.md
# Descriptor Ring Poll Sequencer

This block is the idle-time ownership poller of a bus-mastering network controller. When the channel is quiet and no receive or transmit work is in progress, a programmable interval timer lets it fetch the current receive descriptor and then the current transmit descriptor from host memory. The goal is to learn whether host software has handed either descriptor back to the controller.

Each descriptor is two 32-bit words. Word 1 is always read before word 0. The receive pair is read under one bus tenure. The request is then dropped for at least one cycle, and the transmit pair is read under a second tenure. The fetched pair is kept only when the ownership flag in word 1 is set. Every bus address takes its top byte from a separate high-address input.

The state machine has these states:

- `PS_IDLE`: counting the interval.
- `PS_RX_REQ`: requesting the bus for the receive pair.
- `PS_RX_W1`: reading receive word 1.
- `PS_RX_W0`: reading receive word 0.
- `PS_REARB`: request dropped between the two tenures.
- `PS_TX_REQ`: requesting the bus for the transmit pair.
- `PS_TX_W1`: reading transmit word 1.
- `PS_TX_W0`: reading transmit word 0.
- `PS_FINISH`: done pulse and timer reload.

The transitions are:

- IDLE to RX_REQ when the timer has expired, no activity flag is set and the receive trigger holds.
- IDLE to TX_REQ when the timer has expired, no activity flag is set, the receive trigger fails and transmit polling is on.
- IDLE stays in IDLE with a timer reload when the timer has expired, no activity flag is set and neither half applies.
- RX_REQ to RX_W1 on grant, or to IDLE on activity before grant.
- RX_W1 to RX_W0 on data valid.
- RX_W0 to REARB on data valid, or to FINISH instead when transmit polling is off.
- REARB to TX_REQ, or to IDLE on activity.
- TX_REQ to TX_W1 on grant, or to IDLE on activity before grant.
- TX_W1 to TX_W0 on data valid.
- TX_W0 to FINISH on data valid.
- FINISH to IDLE.

Top module: `ring_poll_seq`

## Requirements
- R1: A poll starts (bus_req rises) only while net_active, rx_active and tx_active are all low. If any of them is high in a cycle where bus_gnt is low, bus_req is low in the next cycle, and an aborted poll reads no word and raises no poll_done.
- R2: The receive half runs when rx_enable is 1 and at least one of these holds: rx_cur_owned is 0, or rx_next_owned is 0 with rx_ring_len greater than 1. Otherwise it is skipped.
- R3: The receive half reads address rx_desc_addr+4 (word 1) and then rx_desc_addr (word 0) while bus_req stays high. Descriptor addresses are 8-byte aligned.
- R4: The transmit half reads tx_desc_addr+4 and then tx_desc_addr under a separate tenure. bus_req is low for at least one cycle after the receive half.
- R5: With tx_poll_off at 1, no transmit word is read.
- R6: The word pair of a half is stored into its rx_w1_q/rx_w0_q or tx_w1_q/tx_w0_q outputs only if bit 31 of the fetched word 1 is 1. Otherwise the outputs keep their previous values.
- R7: Every read address is {addr_hi, 24-bit offset}.
- R8: After reset the timer is expired, so the first poll may start at once. After a poll_done, the next bus_req rises exactly poll_interval+2 cycles later.
- R9: poll_done is a one-cycle pulse after the last word of a completed sequence. It is not raised when nothing was polled.
- R10: During reset, bus_req, bus_rd and poll_done are 0 and all four descriptor outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_active | input | 1 | Network channel busy |
| rx_active | input | 1 | Receive pre/post work busy |
| tx_active | input | 1 | Transmit pre/post work busy |
| rx_enable | input | 1 | Receive enabled |
| tx_poll_off | input | 1 | Suppress transmit half of the poll |
| rx_cur_owned | input | 1 | Controller owns current receive descriptor |
| rx_next_owned | input | 1 | Controller owns next receive descriptor |
| rx_ring_len | input | RLEN_W | Receive ring entry count |
| poll_interval | input | TMR_W | Interval timer reload value |
| addr_hi | input | HI_AW | Top byte of every bus address |
| rx_desc_addr | input | LOW_AW | Current receive descriptor offset |
| tx_desc_addr | input | LOW_AW | Current transmit descriptor offset |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe, address valid |
| bus_addr | output | HI_AW+LOW_AW | Read address |
| rd_dv | input | 1 | Read data valid |
| rd_data | input | DW | Read data |
| rx_w1_q | output | DW | Stored receive word 1 |
| rx_w0_q | output | DW | Stored receive word 0 |
| tx_w1_q | output | DW | Stored transmit word 1 |
| tx_w0_q | output | DW | Stored transmit word 0 |
| poll_done | output | 1 | Completed-poll pulse |

## Verification
The assertions check every cycle that activity without a grant withdraws the request, and that a word-1 read is followed directly by the word-0 read of the same descriptor. They also check that poll_done is a single pulse following a data beat, and that the stored words change only when the held word 1 carried the ownership flag. The bench scenarios cover the rest. These are the trigger combinations of ring length, ownership and enables, and the exact read order and tenure count. They also cover the interval timing, retention of old words after an unowned fetch, and abort before grant followed by a clean retry.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [3:0] {
        PS_IDLE,
        PS_RX_REQ,
        PS_RX_W1,
        PS_RX_W0,
        PS_REARB,
        PS_TX_REQ,
        PS_TX_W1,
        PS_TX_W0,
        PS_FINISH
    } poll_state_t;
endpackage

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [TMR_W-1:0] interval,
    output logic             expired
);
    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (reload)
            count_q <= interval;
        else if (count_q != '0)
            count_q <= count_q - TMR_W'(1);
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/desc_snapshot.sv
module desc_snapshot #(
    parameter int DW      = 32,
    parameter int OWN_BIT = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          w1_stb,
    input  logic          w0_stb,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] w1_q,
    output logic [DW-1:0] w0_q
);
    logic [DW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            w1_q   <= '0;
            w0_q   <= '0;
        end else begin
            if (w1_stb)
                pend_q <= rd_data;
            if (w0_stb && pend_q[OWN_BIT]) begin
                w1_q <= pend_q;
                w0_q <= rd_data;
            end
        end
    end

    // R6
    own_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(w0_q) |-> $past(pend_q[OWN_BIT]));
endmodule

// File: rtl/ring_poll_seq.sv
module ring_poll_seq
    import poll_pkg::*;
#(
    parameter int LOW_AW = 24,
    parameter int HI_AW  = 8,
    parameter int DW     = 32,
    parameter int TMR_W  = 16,
    parameter int RLEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    net_active,
    input  logic                    rx_active,
    input  logic                    tx_active,
    input  logic                    rx_enable,
    input  logic                    tx_poll_off,
    input  logic                    rx_cur_owned,
    input  logic                    rx_next_owned,
    input  logic [RLEN_W-1:0]       rx_ring_len,
    input  logic [TMR_W-1:0]        poll_interval,
    input  logic [HI_AW-1:0]        addr_hi,
    input  logic [LOW_AW-1:0]       rx_desc_addr,
    input  logic [LOW_AW-1:0]       tx_desc_addr,
    output logic                    bus_req,
    input  logic                    bus_gnt,
    output logic                    bus_rd,
    output logic [HI_AW+LOW_AW-1:0] bus_addr,
    input  logic                    rd_dv,
    input  logic [DW-1:0]           rd_data,
    output logic [DW-1:0]           rx_w1_q,
    output logic [DW-1:0]           rx_w0_q,
    output logic [DW-1:0]           tx_w1_q,
    output logic [DW-1:0]           tx_w0_q,
    output logic                    poll_done
);
    localparam int ADDR_W  = HI_AW + LOW_AW;
    localparam int W1_OFS  = DW / 8;
    localparam int OWN_BIT = DW - 1;

    poll_state_t state_q, state_d;
    logic busy_any, rx_go, tx_go, expired, reload;
    logic [LOW_AW-1:0] base_sel;

    assign busy_any = net_active | rx_active | tx_active;
    assign rx_go    = rx_enable &&
                      (!rx_cur_owned || (!rx_next_owned && rx_ring_len > RLEN_W'(1)));
    assign tx_go    = !tx_poll_off;

    poll_interval_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .interval(poll_interval), .expired(expired)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:
                if (expired && !busy_any) begin
                    if (rx_go)      state_d = PS_RX_REQ;
                    else if (tx_go) state_d = PS_TX_REQ;
                end
            PS_RX_REQ:
                if (bus_gnt)       state_d = PS_RX_W1;
                else if (busy_any) state_d = PS_IDLE;
            PS_RX_W1:
                if (rd_dv) state_d = PS_RX_W0;
            PS_RX_W0:
                if (rd_dv) state_d = tx_go ? PS_REARB : PS_FINISH;
            PS_REARB:
                state_d = busy_any ? PS_IDLE : PS_TX_REQ;
            PS_TX_REQ:
                if (bus_gnt)       state_d = PS_TX_W1;
                else if (busy_any) state_d = PS_IDLE;
            PS_TX_W1:
                if (rd_dv) state_d = PS_TX_W0;
            PS_TX_W0:
                if (rd_dv) state_d = PS_FINISH;
            PS_FINISH:
                state_d = PS_IDLE;
            default:
                state_d = PS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_rd    = 1'b0;
        poll_done = 1'b0;
        reload    = 1'b0;
        base_sel  = rx_desc_addr;
        unique case (state_q)
            PS_IDLE:
                reload = expired && !busy_any && !rx_go && !tx_go;
            PS_RX_REQ:
                bus_req = 1'b1;
            PS_RX_W1: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                base_sel = rx_desc_addr + LOW_AW'(W1_OFS);
            end
            PS_RX_W0: begin
                bus_req = 1'b1;
                bus_rd  = 1'b1;
            end
            PS_REARB: ;
            PS_TX_REQ:
                bus_req = 1'b1;
            PS_TX_W1: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                base_sel = tx_desc_addr + LOW_AW'(W1_OFS);
            end
            PS_TX_W0: begin
                bus_req  = 1'b1;
                bus_rd   = 1'b1;
                base_sel = tx_desc_addr;
            end
            PS_FINISH: begin
                poll_done = 1'b1;
                reload    = 1'b1;
            end
            default: ;
        endcase
        bus_addr = {addr_hi, base_sel};
    end

    desc_snapshot #(.DW(DW), .OWN_BIT(OWN_BIT)) u_rx_snap (
        .clk(clk), .rst_n(rst_n),
        .w1_stb(state_q == PS_RX_W1 && rd_dv),
        .w0_stb(state_q == PS_RX_W0 && rd_dv),
        .rd_data(rd_data), .w1_q(rx_w1_q), .w0_q(rx_w0_q)
    );

    desc_snapshot #(.DW(DW), .OWN_BIT(OWN_BIT)) u_tx_snap (
        .clk(clk), .rst_n(rst_n),
        .w1_stb(state_q == PS_TX_W1 && rd_dv),
        .w0_stb(state_q == PS_TX_W0 && rd_dv),
        .rd_data(rd_data), .w1_q(tx_w1_q), .w0_q(tx_w0_q)
    );

    // R1
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_any && !bus_gnt) |=> !bus_req);

    // R3
    word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rd_dv && bus_addr[2]) |=> (bus_rd && !bus_addr[2] && bus_req));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |=> !poll_done);

    // R9
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done |-> $past(rd_dv));

    // R7
    addr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_addr[ADDR_W-1:LOW_AW] == addr_hi));
endmodule

// File: tb/ring_poll_seq_test.sv
module ring_poll_seq_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        net_active = 1'b1, rx_active = 1'b0, tx_active = 1'b0;
    logic        rx_enable = 1'b0, tx_poll_off = 1'b0;
    logic        rx_cur_owned = 1'b1, rx_next_owned = 1'b1;
    logic [15:0] rx_ring_len = 16'd4;
    logic [15:0] poll_interval = 16'd200;
    logic [7:0]  addr_hi = 8'hA5;
    logic [23:0] rx_desc_addr = 24'h000100;
    logic [23:0] tx_desc_addr = 24'h000240;
    logic        bus_req, bus_gnt, bus_rd, rd_dv, poll_done;
    logic [31:0] bus_addr, rd_data;
    logic [31:0] rx_w1_q, rx_w0_q, tx_w1_q, tx_w0_q;

    ring_poll_seq uut (
        .clk(clk), .rst_n(rst_n), .net_active(net_active), .rx_active(rx_active),
        .tx_active(tx_active), .rx_enable(rx_enable), .tx_poll_off(tx_poll_off),
        .rx_cur_owned(rx_cur_owned), .rx_next_owned(rx_next_owned),
        .rx_ring_len(rx_ring_len), .poll_interval(poll_interval), .addr_hi(addr_hi),
        .rx_desc_addr(rx_desc_addr), .tx_desc_addr(tx_desc_addr),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .rd_dv(rd_dv), .rd_data(rd_data), .rx_w1_q(rx_w1_q), .rx_w0_q(rx_w0_q),
        .tx_w1_q(tx_w1_q), .tx_w0_q(tx_w0_q), .poll_done(poll_done)
    );

    int checks = 0, errors = 0;
    logic [31:0] m_rx1, m_rx0, m_tx1, m_tx0;
    logic        hold_gnt = 1'b0;
    logic [31:0] rd_log [256];
    int n_reads = 0, n_arbs = 0, n_done = 0;
    logic prev_req = 1'b0;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a == {addr_hi, rx_desc_addr + 24'd4}) return m_rx1;
        if (a == {addr_hi, rx_desc_addr})         return m_rx0;
        if (a == {addr_hi, tx_desc_addr + 24'd4}) return m_tx1;
        if (a == {addr_hi, tx_desc_addr})         return m_tx0;
        return 32'hDEAD_BEEF;
    endfunction

    // bus and memory responder, acts on falling edges
    initial begin
        bus_gnt = 1'b0; rd_dv = 1'b0; rd_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_gnt = 1'b0; rd_dv = 1'b0; prev_req = 1'b0;
            end else begin
                if (rd_dv) rd_dv = 1'b0;
                else if (bus_rd) begin
                    rd_dv = 1'b1;
                    rd_data = mem_read(bus_addr);
                    rd_log[n_reads[7:0]] = bus_addr;
                    n_reads++;
                end
                bus_gnt = bus_req && !hold_gnt;
                if (bus_req && !prev_req) n_arbs++;
                prev_req = bus_req;
                if (poll_done) n_done++;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        net_active = 1'b1;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    typedef struct packed {
        logic        rx_en;
        logic        tx_off;
        logic        cur_own;
        logic        nxt_own;
        logic [15:0] rlen;
        logic        rxo;
        logic        txo;
        logic        rxp;
        logic        txp;
    } vec_t;

    // rx_en tx_off cur nxt len rx_own tx_own | expect rx_polled tx_polled
    localparam vec_t VECS [9] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd4, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 16'd4, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd4, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'd4, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'd1, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'd4, 1'b1, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd4, 1'b0, 1'b1, 1'b1, 1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd4, 1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd4, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        int r0, a0, d0, k;
        logic [31:0] e_addr [4];
        int ne;
        logic [31:0] keep1, keep0;

        // R10: reset state
        rst_n = 1'b0;
        tick(3);
        chk(bus_req == 0 && bus_rd == 0 && poll_done == 0, "R10 reset bus", {bus_req, bus_rd, poll_done}, 0);
        chk((rx_w1_q | rx_w0_q | tx_w1_q | tx_w0_q) == 0, "R10 reset regs", rx_w1_q | rx_w0_q | tx_w1_q | tx_w0_q, 0);
        rst_n = 1'b1;
        tick(5);
        chk(bus_req == 0, "R1 no request while active", bus_req, 0);

        // table walk
        for (int i = 0; i < 9; i++) begin
            do_reset();
            rx_enable = VECS[i].rx_en; tx_poll_off = VECS[i].tx_off;
            rx_cur_owned = VECS[i].cur_own; rx_next_owned = VECS[i].nxt_own;
            rx_ring_len = VECS[i].rlen;
            m_rx1 = {VECS[i].rxo, 15'h0, 16'h1100 + 16'(i)};
            m_rx0 = 32'h0A00_0000 + 32'(i);
            m_tx1 = {VECS[i].txo, 15'h0, 16'h2200 + 16'(i)};
            m_tx0 = 32'h0B00_0000 + 32'(i);
            r0 = n_reads; a0 = n_arbs; d0 = n_done;
            net_active = 1'b0;
            tick(40);
            ne = 0;
            if (VECS[i].rxp) begin
                e_addr[ne] = {addr_hi, rx_desc_addr + 24'd4}; ne++;
                e_addr[ne] = {addr_hi, rx_desc_addr}; ne++;
            end
            if (VECS[i].txp) begin
                e_addr[ne] = {addr_hi, tx_desc_addr + 24'd4}; ne++;
                e_addr[ne] = {addr_hi, tx_desc_addr}; ne++;
            end
            chk(n_reads - r0 == ne, "R2/R5 read count", n_reads - r0, ne);
            for (int j = 0; j < ne && j < n_reads - r0; j++)
                chk(rd_log[8'(r0 + j)] == e_addr[j], "R3/R4/R7 read address order", rd_log[8'(r0 + j)], e_addr[j]);
            chk(n_arbs - a0 == int'(VECS[i].rxp) + int'(VECS[i].txp), "R4 tenure count", n_arbs - a0, int'(VECS[i].rxp) + int'(VECS[i].txp));
            chk(n_done - d0 == int'(VECS[i].rxp | VECS[i].txp), "R9 done count", n_done - d0, int'(VECS[i].rxp | VECS[i].txp));
            chk(rx_w0_q == ((VECS[i].rxp && VECS[i].rxo) ? m_rx0 : 32'h0), "R6 rx word0", rx_w0_q, (VECS[i].rxp && VECS[i].rxo) ? m_rx0 : 32'h0);
            chk(rx_w1_q == ((VECS[i].rxp && VECS[i].rxo) ? m_rx1 : 32'h0), "R6 rx word1", rx_w1_q, (VECS[i].rxp && VECS[i].rxo) ? m_rx1 : 32'h0);
            chk(tx_w0_q == ((VECS[i].txp && VECS[i].txo) ? m_tx0 : 32'h0), "R6 tx word0", tx_w0_q, (VECS[i].txp && VECS[i].txo) ? m_tx0 : 32'h0);
        end

        // R1: abort before grant, then clean retry
        do_reset();
        rx_enable = 1'b1; tx_poll_off = 1'b0; rx_cur_owned = 1'b0; rx_ring_len = 16'd4;
        m_rx1 = 32'h8000_3333; m_rx0 = 32'h0000_4444; m_tx1 = 32'h8000_5555; m_tx0 = 32'h0000_6666;
        hold_gnt = 1'b1;
        r0 = n_reads; d0 = n_done;
        net_active = 1'b0;
        k = 0;
        while (!bus_req && k < 20) begin tick(1); k++; end
        chk(bus_req == 1, "R8 immediate first poll", bus_req, 1);
        rx_active = 1'b1;
        tick(1);
        chk(bus_req == 0, "R1 request withdrawn on activity", bus_req, 0);
        tick(10);
        chk(n_reads == r0 && n_done == d0, "R1 aborted poll silent", n_reads - r0, 0);
        hold_gnt = 1'b0; rx_active = 1'b0;
        tick(40);
        chk(n_reads - r0 == 4 && n_done - d0 == 1, "R1 retry completes", n_reads - r0, 4);

        // R8 interval and R6 retention across polls
        do_reset();
        poll_interval = 16'd30;
        rx_enable = 1'b1; tx_poll_off = 1'b1; rx_cur_owned = 1'b0;
        m_rx1 = 32'h8000_7777; m_rx0 = 32'h1234_5678;
        net_active = 1'b0;
        k = 0;
        while (!poll_done && k < 60) begin tick(1); k++; end
        chk(poll_done == 1, "R9 done seen", poll_done, 1);
        keep1 = rx_w1_q; keep0 = rx_w0_q;
        chk(keep0 == 32'h1234_5678, "R6 owned capture", keep0, 32'h1234_5678);
        m_rx1 = 32'h0000_9999; m_rx0 = 32'hFFFF_0000;
        k = 0;
        while (!bus_req && k < 100) begin tick(1); k++; end
        chk(k == 32, "R8 interval gap", k, 32);
        tick(20);
        chk(rx_w1_q == keep1 && rx_w0_q == keep0, "R6 unowned fetch retained", rx_w0_q, keep0);

        summary();
        $finish;
    end
endmodule